// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital controller behind a successive-approximation analog-to-digital converter. It steps the converter through three phases: acquiring the input (tracking), resolving it bit by bit (converting) and waiting (idle). All its timing comes from one subsystem clock. From that clock it derives a slower conversion clock and issues one strobe per bit trial. The comparator result for each trial is collected into a result word.

A convert-start pulse begins each cycle of work. A 2-bit mode select decides where acquisition happens. In one mode, software holds the track switch before the start pulse and conversion follows the pulse at once. In the other two modes, a timed acquisition window follows the pulse. Those two modes differ in whether the input is left disconnected or is tracked again once the conversion is done. The result leaves the block as a plain word, qualified by a one-cycle done pulse. There is no back-pressure: the word holds its value until the next done pulse replaces it, and a consumer that misses a pulse can still read the word before the next conversion ends.

Top module: `sar_sequencer`

## Requirements
- R1: The sequencer is always in exactly one of idle, tracking or converting. After reset it is idle, with `done_o`, `sar_clk_o`, `trial_o` and `result_o` all zero.
- R2: Mode values 2'b10 and 2'b00 select pre-tracking. Conversion starts on the cycle after the edge that samples `start_i`, and `done_o` rises at the (13·R+2)-th rising edge after that sampling edge, where R is the divide ratio.
- R3: Mode 2'b01 (post-tracking) and mode 2'b11 (dual-tracking) are the timed modes. In these modes `track_o` is high for exactly T+2 cycles right after the sampling edge, where T is `trk_time_i`. `done_o` rises at edge T+2+13·R+2.
- R4: `track_o` is low in every cycle of a conversion. When idle, it is 0 in post-tracking mode and 1 in dual-tracking mode, and it follows `sw_track_i` in pre-tracking mode.
- R5: `trial_o` is one-hot or zero. Each conversion raises each bit exactly once, on the last subsystem cycle of its conversion-clock period, starting at bit 12 and ending at bit 0.
- R6: The divide ratio R is `sar_div_i`+1. `sar_clk_o` is high for the first ceil(R/2) cycles of each period and low outside the bit trials. For R≥2 it rises exactly 13 times per conversion, starting in phase with each conversion.
- R7: `done_o` lasts one cycle. `result_o` bit i equals `cmp_i` during the strobe of bit i, and `result_o` changes only at the edge that raises `done_o`.
- R8: A `start_i` pulse that arrives while tracking or converting has no effect: timing and result stay unchanged, and no extra conversion follows.
- R9: `trk_time_i` and `sar_div_i` are sampled when a start is accepted. Changing them later does not alter the conversion in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subsystem clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert-start pulse |
| mode_i | input | 2 | Tracking mode select |
| trk_time_i | input | TRK_W | Extra tracking cycles T |
| sar_div_i | input | DIV_W | Conversion clock divide field (ratio = value+1) |
| sw_track_i | input | 1 | Software track request, used while idle in pre-tracking |
| cmp_i | input | 1 | Comparator decision for the current trial |
| track_o | output | 1 | Track switch control (1 = closed) |
| sar_clk_o | output | 1 | Derived conversion clock |
| trial_o | output | NBITS | One-hot bit-trial strobes |
| done_o | output | 1 | One-cycle conversion-done pulse |
| result_o | output | NBITS | Conversion result word |

## Verification
The bench uses the default parameters: 13 trial bits, a 4-bit tracking field and a 3-bit divide field. With these widths it can reach the largest tracking window (17 cycles) and the largest divide ratio (8), as well as the ratio-1 case where the conversion clock cannot toggle. Each vector sets a mode, a tracking time, a divide field and a comparator target, so the bench can check latency, window length and bit order against closed-form counts. Directed runs then inject stray start pulses and change the configuration during a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_TRACK = 2'd1, ST_CONV = 2'd2} seq_state_e;
  typedef enum logic [1:0] {PH_OPEN = 2'd0, PH_BITS = 2'd1, PH_CLOSE = 2'd2} conv_phase_e;
  localparam logic [1:0] MODE_POST = 2'b01;
  localparam logic [1:0] MODE_DUAL = 2'b11;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sar_clk,
  output logic             tick
);
  localparam int CW = DIV_W + 1;
  logic [DIV_W-1:0] cnt;
  logic [CW-1:0]    half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (run)     cnt <= (cnt == div) ? '0 : cnt + 1'b1;
  end

  assign half    = ({1'b0, div} + CW'(2)) >> 1;
  assign tick    = run && (cnt == div);
  assign sar_clk = run && ({1'b0, cnt} < half);

  p_clk_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sar_clk);
endmodule

// File: rtl/sar_track_timer.sv
module sar_track_timer #(
  parameter int TRK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic [TRK_W-1:0] trk,
  output logic             expire
);
  localparam int TW = TRK_W + 1;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (load)                  cnt <= {1'b0, trk} + TW'(1);
    else if (active && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

  p_timer_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && !expire) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int NBITS = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic             finish,
  input  logic             cmp,
  output logic [NBITS-1:0] trial,
  output logic             last,
  output logic             done,
  output logic [NBITS-1:0] result
);
  localparam int IW = $clog2(NBITS);
  logic [IW-1:0]    bidx;
  logic [NBITS-1:0] work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx <= IW'(NBITS - 1);
      work <= '0;
    end else if (restart) begin
      bidx <= IW'(NBITS - 1);
      work <= '0;
    end else if (tick) begin
      work[bidx] <= cmp;
      if (bidx != '0) bidx <= bidx - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= finish;
      if (finish) result <= work;
    end
  end

  assign trial = tick ? (NBITS'(1) << bidx) : '0;
  assign last  = tick && (bidx == '0);

  p_trial_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 13,
  parameter int TRK_W = 4,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [TRK_W-1:0] trk_time_i,
  input  logic [DIV_W-1:0] sar_div_i,
  input  logic             sw_track_i,
  input  logic             cmp_i,
  output logic             track_o,
  output logic             sar_clk_o,
  output logic [NBITS-1:0] trial_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o
);
  seq_state_e       state;
  conv_phase_e      ph;
  logic [DIV_W-1:0] div_q;
  logic             accept, timed, trk_expire, restart, run, tick, last_bit, finish;

  assign accept  = (state == ST_IDLE) && start_i;
  assign timed   = mode_i[0];
  assign restart = (state == ST_CONV) && (ph == PH_OPEN);
  assign run     = (state == ST_CONV) && (ph == PH_BITS);
  assign finish  = (state == ST_CONV) && (ph == PH_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= PH_OPEN;
      div_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          div_q <= sar_div_i;
          ph    <= PH_OPEN;
          state <= timed ? ST_TRACK : ST_CONV;
        end
        ST_TRACK: if (trk_expire) begin
          state <= ST_CONV;
          ph    <= PH_OPEN;
        end
        ST_CONV: unique case (ph)
          PH_OPEN:  ph <= PH_BITS;
          PH_BITS:  if (last_bit) ph <= PH_CLOSE;
          default:  begin
            ph    <= PH_OPEN;
            state <= ST_IDLE;
          end
        endcase
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_TRACK: track_o = 1'b1;
      ST_CONV:  track_o = 1'b0;
      default: begin
        if (mode_i == MODE_POST)      track_o = 1'b0;
        else if (mode_i == MODE_DUAL) track_o = 1'b1;
        else                          track_o = sw_track_i;
      end
    endcase
  end

  sar_track_timer #(.TRK_W(TRK_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(accept && timed), .active(state == ST_TRACK),
    .trk(trk_time_i), .expire(trk_expire)
  );

  sar_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
    .div(div_q), .sar_clk(sar_clk_o), .tick(tick)
  );

  sar_bit_engine #(.NBITS(NBITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .finish(finish), .cmp(cmp_i), .trial(trial_o), .last(last_bit),
    .done(done_o), .result(result_o)
  );

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state inside {ST_IDLE, ST_TRACK, ST_CONV});
  p_open_in_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |-> !track_o);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && ph != PH_CLOSE && start_i) |=> (state == ST_CONV));
  p_div_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(div_q));
endmodule

// File: tb/test_sar_sequencer.sv
`timescale 1ns/1ps
module test_sar_sequencer;
  localparam int NB = 13;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, sw_track_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic [3:0] trk_time_i = '0;
  logic [2:0] sar_div_i = '0;
  logic [NB-1:0] target = '0;
  logic cmp_i, track_o, sar_clk_o, done_o;
  logic [NB-1:0] trial_o, result_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign cmp_i = |(trial_o & target);

  sar_sequencer i_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .trk_time_i(trk_time_i), .sar_div_i(sar_div_i), .sw_track_i(sw_track_i),
    .cmp_i(cmp_i), .track_o(track_o), .sar_clk_o(sar_clk_o),
    .trial_o(trial_o), .done_o(done_o), .result_o(result_o)
  );

  typedef struct packed {
    logic [1:0] mode; logic [3:0] trk; logic [2:0] div; logic [12:0] tgt; logic [7:0] lat;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'b10, 4'd5,  3'd0, 13'h1A5B, 8'd15},
    '{2'b01, 4'd0,  3'd0, 13'h0000, 8'd17},
    '{2'b11, 4'd3,  3'd1, 13'h1FFF, 8'd33},
    '{2'b01, 4'd15, 3'd3, 13'h0AAA, 8'd71},
    '{2'b00, 4'd7,  3'd2, 13'h1555, 8'd41},
    '{2'b11, 4'd15, 3'd7, 13'h0F0F, 8'd123}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [1:0] m, input logic [3:0] t, input logic [2:0] d,
                          input logic [NB-1:0] tg, input int lat, input bit inject);
    int cnt = 0, trk_cyc = 0, rises = 0, good = 0, idx = NB - 1;
    int exp_trk;
    logic prev = 1'b0;
    exp_trk = m[0] ? int'(t) + 2 : 0;
    mode_i = m; trk_time_i = t; sar_div_i = d; target = tg;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && cnt < 400) begin
      if (track_o) trk_cyc++;
      if (sar_clk_o && !prev) rises++;
      prev = sar_clk_o;
      if (trial_o != '0) begin
        if (idx >= 0 && trial_o == (NB'(1) << idx)) good++;
        idx--;
      end
      if (inject && (cnt == 1 || cnt == 20)) start_i = 1'b1;
      else start_i = 1'b0;
      if (inject && cnt == 10) begin sar_div_i = 3'd0; trk_time_i = 4'd0; end
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    chk(cnt == lat, m[0] ? "R3 latency" : "R2 latency", cnt, lat);
    chk(trk_cyc == exp_trk, "R3/R4 track window", trk_cyc, exp_trk);
    chk(good == NB && idx == -1, "R5 trial order", good, NB);
    if (d != 0) chk(rises == NB, "R6 sar clock rises", rises, NB);
    chk(result_o == tg, "R7 result", int'(result_o), int'(tg));
    @(negedge clk);
    chk(!done_o, "R7 done single cycle", done_o, 0);
    if (m == 2'b01)      chk(track_o == 1'b0, "R4 post idle open", track_o, 0);
    else if (m == 2'b11) chk(track_o == 1'b1, "R4 dual idle track", track_o, 1);
    else                 chk(track_o == sw_track_i, "R4 pre follows sw", track_o, sw_track_i);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(track_o == 1'b0 && done_o == 1'b0, "R1 reset outputs", {track_o, done_o}, 0);
    chk(trial_o == '0 && result_o == '0 && !sar_clk_o, "R1 reset data", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mode_i = 2'b10; sw_track_i = 1'b1; #1;
    chk(track_o == 1'b1, "R4 pre idle sw high", track_o, 1);
    sw_track_i = 1'b0; #1;
    chk(track_o == 1'b0, "R4 pre idle sw low", track_o, 0);
    sw_track_i = 1'b1;
    for (int i = 0; i < 6; i++)
      run_conv(VECS[i].mode, VECS[i].trk, VECS[i].div, VECS[i].tgt, int'(VECS[i].lat), 1'b0);
    // R8 / R9: stray starts during tracking and converting, config changed mid-run
    run_conv(2'b01, 4'd4, 3'd1, 13'h1234, 34, 1'b1);
    begin
      int extra = 0;
      for (int k = 0; k < 150; k++) begin
        @(negedge clk);
        if (done_o || track_o) extra++;
      end
      chk(extra == 0, "R8 no extra conversion", extra, 0);
    end
    // R2: pre-tracking with sw track low during conversion
    sw_track_i = 1'b0;
    run_conv(2'b10, 4'd0, 3'd1, 13'h0801, 28, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule